// File: doc/BRIEF.md
# Sleep-State Control Sequencer

This block turns two active-low sleep request lines into one of three operating states. The first line asks for suspend-to-RAM and the second asks for soft-off. The states are active (running), S3 (suspend) and S4/S5 (soft-off). A digital filter cleans up the suspend request before the block uses it. The block will not move straight from one sleep state to the other; it always returns to active first. When the system powers down fully, the suspend request may arrive a short time before the soft-off request. The block allows for this by holding off its decision for a bounded window.

All timing is counted in strobes of a shared timebase tick. The block extends the standby power-on-reset and assesses the 12 V monitor. It latches a memory-voltage select input once after reset release, and it latches two rail-keep configuration bits whenever the configuration can first take effect. From the state and these bits it drives registered rail enables. A sticky fault flag reports under-voltage and over-temperature conditions. Shutdown and critical temperature turn every enable off.

Top module: `slp_seq_ctrl`

## Requirements
- R1: `state_o` encodes the committed state as 2'b00 active, 2'b01 S3 and 2'b10 S4/S5. With both requests high the state is 2'b00, and a low soft-off request leads to 2'b10.
- R2: The suspend request only counts once it has been sampled low on DG_N consecutive ticks. A shorter low pulse has no effect on `state_o`, and no samples are taken while `tick` is low.
- R3: After a filtered suspend request, the block reports active for SKEW_TICKS ticks. If the soft-off request goes low inside that window, the block enters 2'b10 without passing through 2'b01. Otherwise it enters 2'b01.
- R4: `state_o` never changes directly between 2'b01 and 2'b10. A soft-off request made while in S3 leaves the state at 2'b01 until the suspend request is released. A suspend request made while in S4/S5 leaves the state at 2'b10 until the soft-off request is released.
- R5: `por_done_o` rises after `stby_ok` has been high for POR_TICKS ticks. Losing `stby_ok` drops it again. While it is low, the state is held at 2'b00 and every enable, `fault_o` and `mem_sel_o` read 0.
- R6: `mem_sel_o` takes the value of `mem_sel_in` MSEL_TICKS ticks after `por_done_o` rises. Later changes of `mem_sel_in` have no effect until the next reset release.
- R7: The configuration bits are captured on entry to a sleep state, on reset release and on shutdown exit. A change of `cfg_a_in` or `cfg_b_in` made while asleep does not alter the enables.
- R8: The enables {main, mem, dual_a, dual_b} follow the state one cycle later. In active they are 4'b1111. In S3 they are {0, 1, A, B}. In S4/S5 they are {0, 0, A, 0}. A and B are the latched configuration bits.
- R9: One cycle after `shdn` or `ot_crit` is high, all four enables read 0.
- R10: `pwr_good_o` rises after `mon12_ok` has been high for ACT_TICKS ticks, and it falls on the cycle after `mon12_ok` goes low.
- R11: `fault_o` is set after `uv_in` has been high for UV_TICKS ticks, or one cycle after `ot_warn` or `ot_crit` goes high. A shorter under-voltage pulse does not set it. Once set it stays set until `shdn` is asserted or `por_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| stby_ok | input | 1 | Standby supply above its threshold |
| mon12_ok | input | 1 | 12 V monitor above its threshold |
| s3_req_n | input | 1 | Suspend-to-RAM request, active low |
| s5_req_n | input | 1 | Soft-off request, active low |
| shdn | input | 1 | Shutdown, forces all enables off |
| ot_warn | input | 1 | Over-temperature fault level |
| ot_crit | input | 1 | Over-temperature shutdown level |
| uv_in | input | 1 | Under-voltage seen on any output |
| cfg_a_in | input | 1 | Keep dual rail A in both sleep states |
| cfg_b_in | input | 1 | Keep dual rail B in S3 |
| mem_sel_in | input | 1 | Memory-voltage select (1 = 3.3 V, 0 = 2.5 V) |
| state_o | output | 2 | Committed operating state |
| por_done_o | output | 1 | Extended power-on-reset released |
| pwr_good_o | output | 1 | Active state assessed |
| mem_sel_o | output | 1 | Latched memory-voltage select |
| en_main_o | output | 1 | Main rail enable |
| en_mem_o | output | 1 | Memory rail enable |
| en_dual_a_o | output | 1 | Dual rail A enable |
| en_dual_b_o | output | 1 | Dual rail B enable |
| fault_o | output | 1 | Sticky fault flag |

## Verification
The request lines are driven through every pairing that matters:

- A lone suspend request, used to show that the skew window delays S3.
- A soft-off request that follows the suspend request inside the window, which must give S4/S5 with no S3 seen at all.
- A crossed request made while already asleep in either sleep state, which must be blocked, followed by a release that must go through active.
- Short suspend glitches, and a long request made while no tick arrives, which separate the filter from the state decode.

The configuration and select inputs are changed after their capture moment to show that they are held. Under-voltage pulses just below and above the delay, shutdown and both temperature levels tell the sticky fault and the forced-off path apart.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_ACT  = 2'b00,
    ST_S3   = 2'b01,
    ST_S5   = 2'b10,
    ST_PEND = 2'b11
  } slp_st_t;
endpackage

// File: rtl/slp_tickcnt.sv
// Counts timebase ticks while run is high; done once N ticks are seen.
module slp_tickcnt #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(N + 1);
  localparam logic [W-1:0] LIM = W'(N);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/slp_deglitch.sv
// Output follows the input only after N equal consecutive tick samples.
module slp_deglitch #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic [N-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      dout <= 1'b0;
    end else begin
      if (tick) sh <= {sh[N-2:0], din};
      if (&sh)       dout <= 1'b1;
      else if (~|sh) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/slp_seq_ctrl.sv
module slp_seq_ctrl
  import slp_pkg::*;
#(
  parameter int DG_N       = 4,
  parameter int POR_TICKS  = 330,
  parameter int MSEL_TICKS = 300,
  parameter int ACT_TICKS  = 5000,
  parameter int SKEW_TICKS = 20,
  parameter int UV_TICKS   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       stby_ok,
  input  logic       mon12_ok,
  input  logic       s3_req_n,
  input  logic       s5_req_n,
  input  logic       shdn,
  input  logic       ot_warn,
  input  logic       ot_crit,
  input  logic       uv_in,
  input  logic       cfg_a_in,
  input  logic       cfg_b_in,
  input  logic       mem_sel_in,
  output logic [1:0] state_o,
  output logic       por_done_o,
  output logic       pwr_good_o,
  output logic       mem_sel_o,
  output logic       en_main_o,
  output logic       en_mem_o,
  output logic       en_dual_a_o,
  output logic       en_dual_b_o,
  output logic       fault_o
);
  slp_st_t st_q, st_d;
  logic s3_act, s5_act, por_q, shdn_q;
  logic msel_due, msel_taken, skew_done, uv_hit;
  logic cfg_a_q, cfg_b_q;
  logic sleep_entry, cfg_load, force_off;

  // timers sharing one counter design
  slp_tickcnt #(.N(POR_TICKS)) u_por (
    .clk(clk), .rst(rst), .run(stby_ok), .tick(tick), .done(por_done_o));
  slp_tickcnt #(.N(MSEL_TICKS)) u_msel (
    .clk(clk), .rst(rst), .run(por_done_o), .tick(tick), .done(msel_due));
  slp_tickcnt #(.N(ACT_TICKS)) u_act (
    .clk(clk), .rst(rst), .run(mon12_ok), .tick(tick), .done(pwr_good_o));
  slp_tickcnt #(.N(SKEW_TICKS)) u_skew (
    .clk(clk), .rst(rst), .run(st_q == ST_PEND), .tick(tick), .done(skew_done));
  slp_tickcnt #(.N(UV_TICKS)) u_uv (
    .clk(clk), .rst(rst), .run(uv_in && por_done_o && !shdn), .tick(tick),
    .done(uv_hit));

  slp_deglitch #(.N(DG_N)) u_dg (
    .clk(clk), .rst(rst || !por_done_o), .tick(tick), .din(!s3_req_n),
    .dout(s3_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      s5_act <= 1'b0;
      por_q  <= 1'b0;
      shdn_q <= 1'b0;
    end else begin
      s5_act <= !s5_req_n;
      por_q  <= por_done_o;
      shdn_q <= shdn;
    end
  end

  // state decode; the pending state waits out the request skew
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACT:  if (s5_act) st_d = ST_S5;
               else if (s3_act) st_d = ST_PEND;
      ST_PEND: if (s5_act) st_d = ST_S5;
               else if (!s3_act) st_d = ST_ACT;
               else if (skew_done) st_d = ST_S3;
      ST_S3:   if (!s3_act) st_d = ST_ACT;
      ST_S5:   if (!s5_act) st_d = ST_ACT;
      default: st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !por_done_o) st_q <= ST_ACT;
    else st_q <= st_d;
  end

  assign state_o = (st_q == ST_PEND) ? ST_ACT : st_q;

  // configuration capture points
  assign sleep_entry = (st_q == ST_ACT || st_q == ST_PEND) &&
                       (st_d == ST_S3 || st_d == ST_S5) && por_done_o;
  assign cfg_load = sleep_entry || (por_done_o && !por_q) || (shdn_q && !shdn);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a_q <= 1'b0;
      cfg_b_q <= 1'b0;
    end else if (cfg_load) begin
      cfg_a_q <= cfg_a_in;
      cfg_b_q <= cfg_b_in;
    end
  end

  // memory-voltage select, taken once per reset release
  always_ff @(posedge clk) begin
    if (rst || !por_done_o) begin
      mem_sel_o  <= 1'b0;
      msel_taken <= 1'b0;
    end else if (msel_due && !msel_taken) begin
      mem_sel_o  <= mem_sel_in;
      msel_taken <= 1'b1;
    end
  end

  // registered rail enables
  assign force_off = shdn || ot_crit || !por_done_o;

  always_ff @(posedge clk) begin
    if (rst || force_off) begin
      {en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o} <= 4'b0000;
    end else begin
      unique case (state_o)
        ST_S3:   {en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o} <= {2'b01, cfg_a_q, cfg_b_q};
        ST_S5:   {en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o} <= {2'b00, cfg_a_q, 1'b0};
        default: {en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o} <= 4'b1111;
      endcase
    end
  end

  // sticky fault flag
  always_ff @(posedge clk) begin
    if (rst || shdn || !por_done_o) fault_o <= 1'b0;
    else if (uv_hit || ot_warn || ot_crit) fault_o <= 1'b1;
  end
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       shdn,
  input logic       ot_warn,
  input logic       ot_crit,
  input logic [1:0] state_o,
  input logic       por_done_o,
  input logic       mem_sel_o,
  input logic       msel_taken,
  input logic       en_main_o,
  input logic       en_mem_o,
  input logic       en_dual_a_o,
  input logic       en_dual_b_o,
  input logic       fault_o
);
  // R4
  no_s3_to_s5_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'b01 |=> state_o != 2'b10);
  // R4
  no_s5_to_s3_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'b10 |=> state_o != 2'b01);
  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (rst)
    (shdn || ot_crit) |=> !(en_main_o || en_mem_o || en_dual_a_o || en_dual_b_o));
  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o && !shdn && por_done_o |=> fault_o);
  // R11
  ot_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ot_warn || ot_crit) && !shdn && por_done_o |=> fault_o);
  // R6
  msel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    por_done_o && $past(por_done_o) && msel_taken && $past(msel_taken)
    |-> $stable(mem_sel_o));
  // R5
  por_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !por_done_o |=> state_o == 2'b00 && !en_main_o && !fault_o);
endmodule

bind slp_seq_ctrl slp_seq_chk u_chk (
  .clk(clk), .rst(rst), .shdn(shdn), .ot_warn(ot_warn), .ot_crit(ot_crit),
  .state_o(state_o), .por_done_o(por_done_o), .mem_sel_o(mem_sel_o),
  .msel_taken(msel_taken), .en_main_o(en_main_o), .en_mem_o(en_mem_o),
  .en_dual_a_o(en_dual_a_o), .en_dual_b_o(en_dual_b_o), .fault_o(fault_o));

// File: tb/sim_slp_seq_ctrl.sv
`timescale 1ns/1ps
module sim_slp_seq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, stby_ok = 1'b0, mon12_ok = 1'b0;
  logic s3_req_n = 1'b1, s5_req_n = 1'b1, shdn = 1'b0;
  logic ot_warn = 1'b0, ot_crit = 1'b0, uv_in = 1'b0;
  logic cfg_a_in = 1'b1, cfg_b_in = 1'b0, mem_sel_in = 1'b1;
  logic [1:0] state_o;
  logic por_done_o, pwr_good_o, mem_sel_o, fault_o;
  logic en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o;
  int n_chk = 0, n_bad = 0, saw_s3 = 0, illegal = 0;
  logic [1:0] prev_st = 2'b00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slp_seq_ctrl #(.DG_N(3), .POR_TICKS(4), .MSEL_TICKS(3), .ACT_TICKS(5),
                 .SKEW_TICKS(6), .UV_TICKS(3)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .stby_ok(stby_ok), .mon12_ok(mon12_ok),
    .s3_req_n(s3_req_n), .s5_req_n(s5_req_n), .shdn(shdn), .ot_warn(ot_warn),
    .ot_crit(ot_crit), .uv_in(uv_in), .cfg_a_in(cfg_a_in), .cfg_b_in(cfg_b_in),
    .mem_sel_in(mem_sel_in), .state_o(state_o), .por_done_o(por_done_o),
    .pwr_good_o(pwr_good_o), .mem_sel_o(mem_sel_o), .en_main_o(en_main_o),
    .en_mem_o(en_mem_o), .en_dual_a_o(en_dual_a_o), .en_dual_b_o(en_dual_b_o),
    .fault_o(fault_o));

  // state history monitor, reads values settled before the edge
  always @(posedge clk) begin
    if (!rst) begin
      if (state_o == 2'b01) saw_s3 <= saw_s3 + 1;
      if ((prev_st == 2'b01 && state_o == 2'b10) ||
          (prev_st == 2'b10 && state_o == 2'b01)) illegal <= illegal + 1;
    end
    prev_st <= state_o;
  end

  function automatic logic [3:0] ens();
    return {en_main_o, en_mem_o, en_dual_a_o, en_dual_b_o};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wt(3); rst = 1'b0; wt(1);
    // R5 reset state
    chk("R5 por low", 4'(por_done_o), 4'h0);
    chk("R5 enables off", ens(), 4'h0);
    chk("R5 state", 4'(state_o), 4'h0);
    stby_ok = 1'b1; wt(2);
    chk("R5 por still low", 4'(por_done_o), 4'h0);
    wt(10);
    chk("R5 por released", 4'(por_done_o), 4'h1);
    chk("R8 active enables", ens(), 4'hF);
    chk("R6 mem_sel latched", 4'(mem_sel_o), 4'h1);
    mem_sel_in = 1'b0; wt(5);
    chk("R6 mem_sel held", 4'(mem_sel_o), 4'h1);
    // R10 active assessment
    mon12_ok = 1'b1; wt(2);
    chk("R10 not yet good", 4'(pwr_good_o), 4'h0);
    wt(8);
    chk("R10 good", 4'(pwr_good_o), 4'h1);
    mon12_ok = 1'b0; wt(1);
    chk("R10 drop", 4'(pwr_good_o), 4'h0);
    // R2 short glitch
    s3_req_n = 1'b0; wt(2); s3_req_n = 1'b1; wt(20);
    chk("R2 glitch ignored", 4'(state_o), 4'h0);
    chk("R2 never in S3", 4'(saw_s3 != 0), 4'h0);
    // R2 no samples without tick
    tick = 1'b0; s3_req_n = 1'b0; wt(30);
    chk("R2 no tick no change", 4'(state_o), 4'h0);
    tick = 1'b1; wt(6);
    chk("R3 held active in window", 4'(state_o), 4'h0);
    wt(20);
    chk("R1 S3 code", 4'(state_o), 4'h1);
    chk("R8 S3 enables", ens(), 4'b0110);
    cfg_a_in = 1'b0; cfg_b_in = 1'b1; wt(5);
    chk("R7 cfg change asleep ignored", ens(), 4'b0110);
    // R4 blocked S3 -> S5
    s5_req_n = 1'b0; wt(20);
    chk("R4 stays S3", 4'(state_o), 4'h1);
    cfg_a_in = 1'b1; cfg_b_in = 1'b1;
    s3_req_n = 1'b1; wt(20);
    chk("R1 S5 code", 4'(state_o), 4'h2);
    chk("R8 S5 enables", ens(), 4'b0010);
    // R4 blocked S5 -> S3
    s3_req_n = 1'b0; wt(20);
    chk("R4 stays S5", 4'(state_o), 4'h2);
    s5_req_n = 1'b1; wt(30);
    chk("R4 S3 via active", 4'(state_o), 4'h1);
    chk("R4 no direct moves", 4'(illegal), 4'h0);
    s3_req_n = 1'b1; wt(20);
    chk("R1 back active", 4'(state_o), 4'h0);
    chk("R8 active again", ens(), 4'hF);
    // R3 skewed soft-off entry
    wt(1); saw_s3 = 0;
    s3_req_n = 1'b0; wt(6); s5_req_n = 1'b0; wt(20);
    chk("R3 resolved to S5", 4'(state_o), 4'h2);
    chk("R3 S3 never shown", 4'(saw_s3 != 0), 4'h0);
    s3_req_n = 1'b1; s5_req_n = 1'b1; wt(10);
    chk("R1 idle active", 4'(state_o), 4'h0);
    // R9 shutdown
    shdn = 1'b1; wt(1);
    chk("R9 shutdown off", ens(), 4'h0);
    shdn = 1'b0; wt(3);
    // R11 under-voltage
    uv_in = 1'b1; wt(2); uv_in = 1'b0; wt(5);
    chk("R11 short uv ignored", 4'(fault_o), 4'h0);
    uv_in = 1'b1; wt(6);
    chk("R11 uv fault", 4'(fault_o), 4'h1);
    uv_in = 1'b0; wt(5);
    chk("R11 sticky", 4'(fault_o), 4'h1);
    shdn = 1'b1; wt(2); shdn = 1'b0; wt(2);
    chk("R11 cleared by shutdown", 4'(fault_o), 4'h0);
    ot_warn = 1'b1; wt(1); ot_warn = 1'b0; wt(1);
    chk("R11 warn fault", 4'(fault_o), 4'h1);
    shdn = 1'b1; wt(2); shdn = 1'b0; wt(2);
    ot_crit = 1'b1; wt(2);
    chk("R11 crit fault", 4'(fault_o), 4'h1);
    chk("R9 crit off", ens(), 4'h0);
    ot_crit = 1'b0; wt(3);
    chk("R8 recovered", ens(), 4'hF);
    // R5 standby loss
    stby_ok = 1'b0; wt(2);
    chk("R5 por lost", 4'(por_done_o), 4'h0);
    chk("R5 fault cleared", 4'(fault_o), 4'h0);
    chk("R5 off on loss", ens(), 4'h0);
    chk("R5 mem_sel cleared", 4'(mem_sel_o), 4'h0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule